// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Lookup

This block is a 64-entry, fully associative translation buffer for a 64-bit virtual address space that maps to 41-bit physical addresses. Every entry holds a virtual page number, a 13-bit context and a translation word. The translation word carries a valid flag, a global flag, a 2-bit page size (8 KB, 64 KB, 512 KB or 4 MB), a privileged-only flag, a writable flag, a side-effect flag, a no-fault-only flag, an invert-endian flag and a used flag. Software fills entries through a simple indexed write port. Replacement policy belongs to the surrounding logic.

A lookup presents a virtual address, an access type (load, store, no-fault load or instruction fetch), the user-mode flag, a trap-level-nonzero flag and a context selector. In the same cycle, the block compares all entries in parallel. It returns exactly one outcome: translated, miss, access fault or store-protection trap. It also returns the physical address and attributes of the winning entry. On the next clock edge it updates the used bit, the fault status register, the fault address register and the tag-access register. A status acknowledge input clears the status register, which gives the overflow flag its meaning.

Top module: `vps_tlb`

## Requirements
- R1: An entry matches when it is valid, its virtual page number equals lookup VA[63:13] in every bit at or above bit 13+3·size, and it is either global or its context equals the lookup context. When several entries match, the lowest index wins, and `lk_hit` reports that a match exists.
- R2: On a hit, `lk_pa[40:13]` takes the entry's page-frame bits at and above position 13+3·size and the VA bits below that position. `lk_pa[12:0]` is zero, and `lk_pa` is zero when there is no hit.
- R3: The lookup context depends on the access. A data access with `lk_csel` 0 uses `prim_ctx`, with 1 uses `sec_ctx`, and with 2 or 3 uses context 0. A fetch (`lk_type`=3) uses `prim_ctx` when `lk_tl`=0 and context 0 otherwise.
- R4: A data access (`lk_type` 0 = load, 1 = store, 2 = no-fault load) raises `lk_fault` in three cases, which may combine: a user access to a privileged page, a no-fault load to a side-effect page, or a load or store to a no-fault-only page.
- R5: `lk_prot` is raised only for a store to a non-writable page when no R4 cause applies.
- R6: A fetch faults only for a user access to a privileged page. The side-effect and no-fault-only flags do not affect a fetch.
- R7: On a fault or protection trap, `fsr` is loaded with the following bits:
  - bit 0: valid.
  - bit 1: overflow, set when the valid bit was already set and not acknowledged in the same cycle.
  - bit 2: the access is a store.
  - bit 3: the access is a no-fault load.
  - bits 5:4: context type (0 primary, 1 secondary, 2 nucleus; for a fetch, 2 when `lk_tl`=1 and 0 otherwise).
  - bit 6: the access is not a user access.
  - bit 7: privilege cause.
  - bit 8: side-effect cause.
  - bit 9: no-fault-only cause.

  Otherwise `stat_ack` clears `fsr`.
- R8: `far` captures the lookup VA on a fault or protection trap. It is left unchanged on a miss or a clean hit.
- R9: On a fault, protection trap or miss, `tag_acc` is loaded with {VA[63:13], lookup context}.
- R10: A clean hit (`lk_ok`) sets the entry's used bit. `lk_used` reports the used bit of the winning entry before the lookup. `lk_swap` is set on a clean data hit to an invert-endian page. An entry write clears the used bit.
- R11: Every request produces exactly one of `lk_ok`, `lk_miss`, `lk_fault`, `lk_prot`. None of them is raised without `lk_req`, and after reset all registers are zero and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 51 | Virtual page number (VA[63:13]) |
| wr_ctx | input | 13 | Entry context |
| wr_ppn | input | 28 | Page frame (PA[40:13]) |
| wr_attr | input | 9 | Attribute bits: 0 valid, 1 global, 3:2 size, 4 privileged, 5 writable, 6 side-effect, 7 no-fault-only, 8 invert-endian |
| prim_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_type | input | 2 | 0 load, 1 store, 2 no-fault load, 3 fetch |
| lk_user | input | 1 | User-mode access |
| lk_tl | input | 1 | Trap level nonzero |
| lk_csel | input | 2 | Data context select: 0 primary, 1 secondary, 2/3 nucleus |
| stat_ack | input | 1 | Clears the status register |
| lk_hit | output | 1 | A matching entry exists |
| lk_ok | output | 1 | Translated without fault |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Access fault |
| lk_prot | output | 1 | Store-protection trap |
| lk_pa | output | 41 | Physical address |
| lk_wr_ok | output | 1 | Winning entry is writable |
| lk_swap | output | 1 | Byte-swap attribute for a clean data hit |
| lk_used | output | 1 | Used bit of the winning entry before the lookup |
| fsr | output | 10 | Fault status register |
| far | output | 64 | Fault address register |
| tag_acc | output | 64 | Tag-access register |

## Verification
The outcome flags, `lk_pa`, `lk_wr_ok`, `lk_swap` and `lk_used` are combinational and valid in the request cycle itself. The bench drives each request just after a falling edge and samples these outputs one nanosecond later, before the rising edge. The `fsr`, `far`, `tag_acc` and used-bit effects appear after the rising edge that ends the request cycle. The bench checks them one nanosecond past that edge, against a bench-side model that advances at the same edge. Directed cases cover several situations: overlapping matches, global entries, each page size, combined fault causes, overflow with and without acknowledge, and the used bit across repeated hits. These run alongside seeded random lookups drawn from a small pool of pages and contexts, so that hits and multiple matches are frequent.

// File: rtl/vps_tlb.sv
module vps_tlb #(
  parameter int NUM_ENT = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  parameter int PG_SH   = 13,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int VPN_W  = VA_W - PG_SH,
  localparam int PPN_W  = PA_W - PG_SH,
  localparam int TA_W   = VPN_W + CTX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [8:0]       wr_attr,
  input  logic [CTX_W-1:0] prim_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [1:0]       lk_type,
  input  logic             lk_user,
  input  logic             lk_tl,
  input  logic [1:0]       lk_csel,
  input  logic             stat_ack,
  output logic             lk_hit,
  output logic             lk_ok,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic             lk_prot,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_wr_ok,
  output logic             lk_swap,
  output logic             lk_used,
  output logic [9:0]       fsr,
  output logic [VA_W-1:0]  far,
  output logic [TA_W-1:0]  tag_acc
);
  localparam int A_V = 0, A_G = 1, A_SZ = 2, A_PRIV = 4, A_W = 5, A_SE = 6, A_NFO = 7, A_IE = 8;

  logic [VPN_W-1:0] e_vpn  [NUM_ENT];
  logic [CTX_W-1:0] e_ctx  [NUM_ENT];
  logic [PPN_W-1:0] e_ppn  [NUM_ENT];
  logic [8:0]       e_attr [NUM_ENT];
  logic [NUM_ENT-1:0] e_used;
  logic [NUM_ENT-1:0] match;

  logic             is_fetch, is_store, is_nfl;
  logic [CTX_W-1:0] ctx;
  logic [1:0]       ctype;

  assign is_fetch = (lk_type == 2'd3);
  assign is_store = (lk_type == 2'd1);
  assign is_nfl   = (lk_type == 2'd2);

  always_comb begin
    if (is_fetch) begin
      ctx   = lk_tl ? '0 : prim_ctx;
      ctype = lk_tl ? 2'd2 : 2'd0;
    end else begin
      case (lk_csel)
        2'd0:    begin ctx = prim_ctx; ctype = 2'd0; end
        2'd1:    begin ctx = sec_ctx;  ctype = 2'd1; end
        default: begin ctx = '0;       ctype = 2'd2; end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [VPN_W-1:0] vmask;
    assign vmask = {VPN_W{1'b1}} << (3 * e_attr[g][A_SZ+:2]);
    assign match[g] = e_attr[g][A_V]
                    && (((e_vpn[g] ^ lk_va[VA_W-1:PG_SH]) & vmask) == '0)
                    && (e_attr[g][A_G] || (e_ctx[g] == ctx));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  logic [8:0]       sa;
  logic [PPN_W-1:0] pmask, ppn;
  logic             hit, c_priv, c_se, c_nfo;

  assign hit    = |match;
  assign sa     = e_attr[sel];
  assign pmask  = {PPN_W{1'b1}} << (3 * sa[A_SZ+:2]);
  assign ppn    = (e_ppn[sel] & pmask) | (lk_va[PA_W-1:PG_SH] & ~pmask);

  assign c_priv = sa[A_PRIV] & lk_user;
  assign c_se   = ~is_fetch & is_nfl & sa[A_SE];
  assign c_nfo  = ~is_fetch & ~is_nfl & sa[A_NFO];

  assign lk_hit   = lk_req & hit;
  assign lk_miss  = lk_req & ~hit;
  assign lk_fault = lk_hit & (c_priv | c_se | c_nfo);
  assign lk_prot  = lk_hit & ~lk_fault & is_store & ~sa[A_W];
  assign lk_ok    = lk_hit & ~lk_fault & ~lk_prot;
  assign lk_pa    = lk_hit ? {ppn, {PG_SH{1'b0}}} : '0;
  assign lk_wr_ok = lk_hit & sa[A_W];
  assign lk_swap  = lk_ok & ~is_fetch & sa[A_IE];
  assign lk_used  = lk_hit & e_used[sel];

  logic v_live;
  assign v_live = fsr[0] & ~stat_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr     <= '0;
      far     <= '0;
      tag_acc <= '0;
      e_used  <= '0;
      for (int i = 0; i < NUM_ENT; i++) e_attr[i] <= '0;
    end else begin
      if (lk_fault || lk_prot) begin
        fsr <= {c_nfo, c_se, c_priv, ~lk_user, ctype, is_nfl, is_store, v_live, 1'b1};
        far <= lk_va;
      end else if (stat_ack) begin
        fsr <= '0;
      end
      if (lk_req && !lk_ok)
        tag_acc <= {lk_va[VA_W-1:PG_SH], ctx};
      if (lk_ok)
        e_used[sel] <= 1'b1;
      if (wr_en) begin
        e_attr[wr_idx] <= wr_attr;
        e_used[wr_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx] <= wr_vpn;
      e_ctx[wr_idx] <= wr_ctx;
      e_ppn[wr_idx] <= wr_ppn;
    end
  end
endmodule

module vps_tlb_chk #(
  parameter int VA_W = 64,
  parameter int TA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic [1:0]      lk_type,
  input logic            stat_ack,
  input logic            lk_ok,
  input logic            lk_miss,
  input logic            lk_fault,
  input logic            lk_prot,
  input logic            lk_hit,
  input logic [9:0]      fsr,
  input logic [VA_W-1:0] far,
  input logic [TA_W-1:0] tag_acc
);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> $countones({lk_ok, lk_miss, lk_fault, lk_prot}) == 1);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !(lk_ok || lk_miss || lk_fault || lk_prot || lk_hit));
  p_prot_store_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot |-> (lk_type == 2'd1));
  p_far_keep_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && (lk_miss || lk_ok)) |=> $stable(far));
  p_far_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault || lk_prot) |=> (far == $past(lk_va)) && fsr[0]);
  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_fault || lk_prot) && fsr[0] && !stat_ack) |=> fsr[1]);
  p_fsr_keep_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss && !stat_ack) |=> $stable(fsr));
  p_tag_on_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss || lk_fault || lk_prot) |=> tag_acc[TA_W-1:13] == $past(lk_va[VA_W-1:13]));
endmodule

bind vps_tlb vps_tlb_chk #(.VA_W(VA_W), .TA_W(TA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_type(lk_type),
  .stat_ack(stat_ack), .lk_ok(lk_ok), .lk_miss(lk_miss), .lk_fault(lk_fault),
  .lk_prot(lk_prot), .lk_hit(lk_hit), .fsr(fsr), .far(far), .tag_acc(tag_acc));

// File: tb/tb_vps_tlb.sv
module tb_vps_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [50:0] wr_vpn = 0;
  logic [12:0] wr_ctx = 0;
  logic [27:0] wr_ppn = 0;
  logic [8:0]  wr_attr = 0;
  logic [12:0] prim_ctx = 0, sec_ctx = 0;
  logic        lk_req = 0;
  logic [63:0] lk_va = 0;
  logic [1:0]  lk_type = 0;
  logic        lk_user = 0, lk_tl = 0;
  logic [1:0]  lk_csel = 0;
  logic        stat_ack = 0;
  logic        lk_hit, lk_ok, lk_miss, lk_fault, lk_prot, lk_wr_ok, lk_swap, lk_used;
  logic [40:0] lk_pa;
  logic [9:0]  fsr;
  logic [63:0] far, tag_acc;

  vps_tlb dut (.*);

  int n_chk = 0, n_bad = 0;

  logic [50:0] m_vpn [64];
  logic [12:0] m_ctx [64];
  logic [27:0] m_ppn [64];
  logic [8:0]  m_attr [64];
  logic        m_used [64];
  logic [9:0]  m_fsr = 0;
  logic [63:0] m_far = 0, m_tag = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [50:0] vpn, input logic [12:0] c,
                     input logic [27:0] ppn, input logic [8:0] attr);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_ctx = c; wr_ppn = ppn; wr_attr = attr;
    @(negedge clk);
    wr_en = 0;
    m_vpn[idx] = vpn; m_ctx[idx] = c; m_ppn[idx] = ppn; m_attr[idx] = attr; m_used[idx] = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] typ, input logic usr,
                      input logic tl, input logic [1:0] cs, input logic ack);
    logic [12:0] c; logic [1:0] ct; int s; logic [27:0] pm, ppn;
    logic xp, xs, xn, xf, xpr, xok, fetch;
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_type = typ; lk_user = usr; lk_tl = tl; lk_csel = cs; stat_ack = ack;
    fetch = (typ == 3);
    if (fetch) begin c = tl ? 13'd0 : prim_ctx; ct = tl ? 2'd2 : 2'd0; end
    else if (cs == 0) begin c = prim_ctx; ct = 0; end
    else if (cs == 1) begin c = sec_ctx; ct = 1; end
    else begin c = 0; ct = 2; end
    s = -1;
    for (int i = 63; i >= 0; i--) begin
      logic [50:0] vm;
      vm = {51{1'b1}} << (3 * m_attr[i][3:2]);
      if (m_attr[i][0] && (((m_vpn[i] ^ va[63:13]) & vm) == 0) && (m_attr[i][1] || m_ctx[i] == c))
        s = i;
    end
    #1;
    chk("R1 hit", 128'(lk_hit), 128'(s >= 0));
    if (s < 0) begin
      chk("R11 miss outcome", 128'({lk_ok, lk_miss, lk_fault, lk_prot}), 128'(4'b0100));
      chk("R2 pa on miss", 128'(lk_pa), 128'(0));
      m_tag = {va[63:13], c};
    end else begin
      pm  = {28{1'b1}} << (3 * m_attr[s][3:2]);
      ppn = (m_ppn[s] & pm) | (va[40:13] & ~pm);
      xp  = m_attr[s][4] & usr;
      xs  = !fetch && typ == 2 && m_attr[s][6];
      xn  = !fetch && typ != 2 && m_attr[s][7];
      xf  = xp | xs | xn;
      xpr = !xf && typ == 1 && !m_attr[s][5];
      xok = !xf && !xpr;
      chk(fetch ? "R6 fetch outcome" : "R4 R5 data outcome",
          128'({lk_ok, lk_miss, lk_fault, lk_prot}), 128'({xok, 1'b0, xf, xpr}));
      chk("R2 pa", 128'(lk_pa), 128'({ppn, 13'd0}));
      chk("R10 attrs", 128'({lk_wr_ok, lk_swap, lk_used}),
          128'({m_attr[s][5], xok & !fetch & m_attr[s][8], m_used[s]}));
      if (xok) m_used[s] = 1;
      else begin
        m_tag = {va[63:13], c};
        m_fsr = {xn, xs, xp, !usr, ct, typ == 2, typ == 1, m_fsr[0] & !ack, 1'b1};
        m_far = va;
      end
      if (xok && ack) m_fsr = 0;
    end
    if (s < 0 && ack) m_fsr = 0;
    @(posedge clk); #1;
    lk_req = 0; stat_ack = 0;
    chk("R7 fsr", 128'(fsr), 128'(m_fsr));
    chk("R8 far", 128'(far), 128'(m_far));
    chk("R9 tag_acc", 128'(tag_acc), 128'(m_tag));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [50:0] pool [8];
  initial begin
    for (int i = 0; i < 64; i++) begin
      m_vpn[i] = 0; m_ctx[i] = 0; m_ppn[i] = 0; m_attr[i] = 0; m_used[i] = 0;
    end
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset fsr", 128'(fsr), 128'(0));
    chk("R11 reset far/tag", 128'({far, tag_acc}), 128'(0));
    chk("R11 idle outcomes", 128'({lk_ok, lk_miss, lk_fault, lk_prot, lk_hit}), 128'(0));
    rst_n = 1;
    prim_ctx = 13'd7; sec_ctx = 13'd9;
    look(64'h0000_1234_5678_0000, 0, 0, 0, 0, 0);          // R11 all invalid -> miss, R9
    // R1 lowest index wins, R10 used across hits
    put(5, 51'h12345, 13'd7, 28'h00aaaaa, 9'b0_0010_0001);
    put(2, 51'h12345, 13'd7, 28'h00bbbbb, 9'b1_0010_0001);
    look({51'h12345, 13'h1ff}, 0, 0, 0, 0, 0);
    look({51'h12345, 13'h1ff}, 0, 0, 0, 0, 0);
    // R3 secondary and nucleus selection, global bypass
    look({51'h12345, 13'h0}, 0, 0, 0, 1, 0);
    put(9, 51'h777, 13'd100, 28'h0123456, 9'b0_0010_0011);
    look({51'h777, 13'h0}, 0, 0, 0, 2, 0);
    look({51'h777, 13'h0}, 3, 0, 1, 0, 0);                 // R3 fetch at tl>0
    // R2 each page size
    for (int z = 0; z < 4; z++) begin
      put(20 + z, 51'h4000 + 51'(z << 20), 13'd7, 28'hfffffff, 9'(32'b10_0001 | (z << 2)));
      look({51'h4000 + 51'(z << 20) + 51'h1ff, 13'h0}, 0, 0, 0, 0, 0);
    end
    // R4 multiple causes, R7 overflow and ack
    put(30, 51'h9999, 13'd7, 28'h1, 9'b0_1001_0001);
    look({51'h9999, 13'h0}, 1, 1, 0, 0, 0);                 // priv+nfo
    look({51'h9999, 13'h0}, 1, 1, 0, 0, 0);                 // overflow
    chk("R7 overflow set", 128'(fsr[1]), 128'(1));
    look({51'h9999, 13'h0}, 0, 1, 0, 0, 1);                 // ack same cycle -> no overflow
    chk("R7 ack suppresses overflow", 128'(fsr[1]), 128'(0));
    put(31, 51'haaaa, 13'd7, 28'h2, 9'b0_0100_0001);
    look({51'haaaa, 13'h0}, 2, 0, 0, 0, 0);                 // R4 nf load to side effect
    look({51'haaaa, 13'h0}, 1, 0, 0, 0, 0);                 // R5 prot
    look({51'haaaa, 13'h0}, 3, 0, 0, 0, 0);                 // R6 fetch ignores flags
    look({51'h9999, 13'h0}, 3, 1, 0, 0, 0);                 // R6 fetch priv fault
    look({51'h5, 13'h0}, 0, 0, 0, 0, 1);                    // R8 miss keeps far, ack clears
    // random phase
    for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom} & ~51'h1ff;
    for (int i = 0; i < 64; i++) begin
      logic [8:0] a;
      logic [12:0] cc [3];
      cc[0] = 13'd7; cc[1] = 13'd9; cc[2] = 13'h1abc;
      a = 9'($urandom);
      a[0] = ($urandom % 4) != 0;
      put(i, pool[$urandom % 8] | 51'($urandom % 512), cc[$urandom % 3], 28'($urandom), a);
    end
    for (int k = 0; k < 1500; k++) begin
      logic [12:0] cc [3];
      cc[0] = 13'd7; cc[1] = 13'd9; cc[2] = 13'h1abc;
      prim_ctx = cc[$urandom % 3]; sec_ctx = cc[$urandom % 3];
      look({pool[$urandom % 8] | 51'($urandom % 512), 13'($urandom)},
           2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 8) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule